// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block carries out the stack half of subroutine call, subroutine return, return from an interrupt service routine, push and pop. It owns an 8-bit stack pointer and drives a single-port internal RAM with an 8-bit address, making exactly one RAM access per clock. The stack grows upward. Storing moves the pointer up by one and then writes at the new location. Loading reads at the current location and then moves the pointer down by one.

The surrounding core pulses `start` together with an operation code and the operands that code needs. A call needs the return address and the target. Push and pop need a direct RAM address. The sequencer then runs two busy cycles and raises `done` on the second one. Address computation, interrupt arbitration and decode stay outside the block. The RAM is expected to return read data combinationally for the address driven in the same cycle.

The state machine has the states IDLE, CALL_LO, CALL_HI, RET_HI, RET_LO, PUSH_RD, PUSH_WR, POP_RD and POP_WR. Its transitions are:
- IDLE goes to CALL_LO for a call, to RET_HI for a return or an interrupt return, to PUSH_RD for a push and to POP_RD for a pop.
- CALL_LO goes to CALL_HI, RET_HI to RET_LO, PUSH_RD to PUSH_WR and POP_RD to POP_WR.
- CALL_HI, RET_LO, PUSH_WR and POP_WR all go back to IDLE.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_out` is 0x07, `pc_out` is 0x0000, and `busy`, `done`, `ram_we` and `irq_release` are all 0.
- R2: Push (op code 3) reads RAM at `dir_addr` in its first busy cycle. In its second busy cycle it writes that byte at `sp_out`+1, and `sp_out` then rises by one.
- R3: Pop (op code 4) reads RAM at `sp_out` in its first busy cycle, after which `sp_out` falls by one. In its second busy cycle it writes the byte it read to `dir_addr`.
- R4: Call (op code 0) writes bits 7..0 of `ret_addr` at `sp_out`+1, then bits 15..8 of `ret_addr` at the next address up. The pointer ends two higher, and `pc_out` equals `target` during `done` and after it.
- R5: Return (op code 1) reads the high byte at `sp_out`, then the low byte one address below it. The pointer ends two lower, and `pc_out` equals {high, low} during `done` and after it.
- R6: Interrupt return (op code 2) behaves exactly like return. In addition, it pulses `irq_release` during its `done` cycle if, and only if, `in_isr` was 1 when the operation started.
- R7: The stack pointer wraps modulo 256 in both directions. `sp_out` changes by one at the end of each cycle that accesses the stack: both cycles of a call or a return, the second cycle of a push, and the first cycle of a pop.
- R8: A `start` that arrives while `busy` is 1 is ignored. A `start` with op codes 5, 6 or 7 is also ignored: no cycle becomes busy, no RAM write happens and the pointer does not change.
- R9: Every accepted operation makes `busy` 1 for exactly two cycles, starting in the cycle after the `start` edge. `done` is 1 only in the second of those cycles, and `ram_we` is never 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation: 0 call, 1 return, 2 interrupt return, 3 push, 4 pop |
| ret_addr | input | 16 | Address to save on a call |
| target | input | 16 | New PC for a call |
| dir_addr | input | 8 | RAM source for push, RAM destination for pop |
| in_isr | input | 1 | A service routine is running (used by interrupt return) |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data for `ram_addr`, same cycle |
| pc_out | output | 16 | New program counter, held between operations |
| done | output | 1 | Final cycle of an operation |
| irq_release | output | 1 | One-cycle pulse that re-enables equal and lower interrupt levels |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | An operation is in progress |

## Verification
Several properties are checked on every cycle:
- the pointer never moves by more than one per clock, and is never told to step up and down at once;
- `done` always returns the machine to idle, and a busy cycle that is not final is always followed by another;
- `irq_release` only appears with `done`;
- nothing is written while the machine is idle.

Other behaviour only the bench scenarios can show. These are the addresses and byte order of each access, the values restored into `pc_out`, and the dependence of `irq_release` on `in_isr`. They also include pointer wrap past 0x00 and 0xFF, and the fact that a start strobe during busy cycles or with a reserved code leaves the state untouched. The bench shows these by comparing against its own stack model and RAM image on every clock.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_CALL = 3'd0,
        OP_RET  = 3'd1,
        OP_RETI = 3'd2,
        OP_PUSH = 3'd3,
        OP_POP  = 3'd4
    } seq_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CALL_LO,
        S_CALL_HI,
        S_RET_HI,
        S_RET_LO,
        S_PUSH_RD,
        S_PUSH_WR,
        S_POP_RD,
        S_POP_WR
    } seq_state_t;

endpackage

// File: rtl/stack_seq_ptr.sv
module stack_seq_ptr #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_down,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] ONE = 1;

    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_RESET;
        end else if (step_up) begin
            sp_q <= sp_q + ONE;
        end else if (step_down) begin
            sp_q <= sp_q - ONE;
        end
    end

    assign sp = sp_q;

    // R7
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q != $past(sp_q)) |-> ((sp_q == $past(sp_q) + ONE) || (sp_q == $past(sp_q) - ONE)));

    // R7
    step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_down));

endmodule

// File: rtl/stack_seq_fsm.sv
module stack_seq_fsm
    import stack_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PC_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [PC_W-1:0]   target,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              in_isr,
    input  logic [ADDR_W-1:0] sp,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              step_up,
    output logic              step_down,
    output logic [PC_W-1:0]   pc_out,
    output logic              done,
    output logic              irq_release,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] ONE = 1;

    seq_state_t        state_q, state_d;
    logic [PC_W-1:0]   ret_q, tgt_q, pc_q;
    logic [ADDR_W-1:0] dir_q;
    logic [DATA_W-1:0] byte_q;
    logic              isr_q, reti_q;
    logic [ADDR_W-1:0] sp_next;

    assign sp_next = sp + ONE;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    case (seq_op_t'(op))
                        OP_CALL:         state_d = S_CALL_LO;
                        OP_RET, OP_RETI: state_d = S_RET_HI;
                        OP_PUSH:         state_d = S_PUSH_RD;
                        OP_POP:          state_d = S_POP_RD;
                        default:         state_d = S_IDLE;
                    endcase
                end
            end
            S_CALL_LO: state_d = S_CALL_HI;
            S_CALL_HI: state_d = S_IDLE;
            S_RET_HI:  state_d = S_RET_LO;
            S_RET_LO:  state_d = S_IDLE;
            S_PUSH_RD: state_d = S_PUSH_WR;
            S_PUSH_WR: state_d = S_IDLE;
            S_POP_RD:  state_d = S_POP_WR;
            S_POP_WR:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ram_addr    = sp;
        ram_we      = 1'b0;
        ram_wdata   = '0;
        step_up     = 1'b0;
        step_down   = 1'b0;
        done        = 1'b0;
        irq_release = 1'b0;
        pc_out      = pc_q;
        unique case (state_q)
            S_IDLE: begin
            end
            S_CALL_LO: begin
                ram_addr  = sp_next;
                ram_we    = 1'b1;
                ram_wdata = ret_q[DATA_W-1:0];
                step_up   = 1'b1;
            end
            S_CALL_HI: begin
                ram_addr  = sp_next;
                ram_we    = 1'b1;
                ram_wdata = ret_q[PC_W-1:DATA_W];
                step_up   = 1'b1;
                done      = 1'b1;
                pc_out    = tgt_q;
            end
            S_RET_HI: begin
                step_down = 1'b1;
            end
            S_RET_LO: begin
                step_down   = 1'b1;
                done        = 1'b1;
                pc_out      = {byte_q, ram_rdata};
                irq_release = reti_q & isr_q;
            end
            S_PUSH_RD: begin
                ram_addr = dir_q;
            end
            S_PUSH_WR: begin
                ram_addr  = sp_next;
                ram_we    = 1'b1;
                ram_wdata = byte_q;
                step_up   = 1'b1;
                done      = 1'b1;
            end
            S_POP_RD: begin
                step_down = 1'b1;
            end
            S_POP_WR: begin
                ram_addr  = dir_q;
                ram_we    = 1'b1;
                ram_wdata = byte_q;
                done      = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Operand capture and held results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q  <= '0;
            tgt_q  <= '0;
            pc_q   <= '0;
            dir_q  <= '0;
            byte_q <= '0;
            isr_q  <= 1'b0;
            reti_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                ret_q  <= ret_addr;
                tgt_q  <= target;
                dir_q  <= dir_addr;
                isr_q  <= in_isr;
                reti_q <= (seq_op_t'(op) == OP_RETI);
            end
            if (state_q == S_RET_HI || state_q == S_PUSH_RD || state_q == S_POP_RD) begin
                byte_q <= ram_rdata;
            end
            if (done) begin
                pc_q <= pc_out;
            end
        end
    end

    assign busy = (state_q != S_IDLE);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && done));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_release |-> done);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_we);

    // R8
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (state_q != S_IDLE));

endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                PC_W     = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [PC_W-1:0]   target,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              in_isr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [PC_W-1:0]   pc_out,
    output logic              done,
    output logic              irq_release,
    output logic [ADDR_W-1:0] sp_out,
    output logic              busy
);

    logic              step_up, step_down;
    logic [ADDR_W-1:0] sp;

    stack_seq_ptr #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (step_up),
        .step_down (step_down),
        .sp        (sp)
    );

    stack_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .ret_addr    (ret_addr),
        .target      (target),
        .dir_addr    (dir_addr),
        .in_isr      (in_isr),
        .sp          (sp),
        .ram_rdata   (ram_rdata),
        .ram_addr    (ram_addr),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata),
        .step_up     (step_up),
        .step_down   (step_down),
        .pc_out      (pc_out),
        .done        (done),
        .irq_release (irq_release),
        .busy        (busy)
    );

    assign sp_out = sp;

endmodule

// File: tb/stack_seq_bench.sv
module stack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] ret_addr = 16'h0;
    logic [15:0] target = 16'h0;
    logic [7:0]  dir_addr = 8'h0;
    logic        in_isr = 1'b0;
    logic [7:0]  ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic [15:0] pc_out;
    logic        done;
    logic        irq_release;
    logic [7:0]  sp_out;
    logic        busy;

    logic [7:0]  mem [256];
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [7:0]  exp_sp;
    logic [15:0] exp_pc;
    logic        exp_busy;

    stack_seq u_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ret_addr(ret_addr),
        .target(target), .dir_addr(dir_addr), .in_isr(in_isr), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pc_out(pc_out),
        .done(done), .irq_release(irq_release), .sp_out(sp_out), .busy(busy)
    );

    always #10 clk = ~clk;

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_cycle(input string tag);
        check(busy == exp_busy, {tag, " R9 busy"}, 32'(busy), 32'(exp_busy));
        check(sp_out == exp_sp, {tag, " R7 sp"}, 32'(sp_out), 32'(exp_sp));
        if (!exp_busy) begin
            check(!ram_we && !done && !irq_release, {tag, " R9 idle quiet"},
                  {29'd0, ram_we, done, irq_release}, 32'd0);
        end
    endtask

    task automatic do_op(input logic [2:0] o, input logic [15:0] ra, input logic [15:0] tg,
                         input logic [7:0] da, input bit isr, input bit ghost, input string tag);
        logic [7:0]  sp0;
        logic [7:0]  hi;
        logic [7:0]  rd;
        logic [15:0] pc_e;
        sp0 = exp_sp;
        hi = 8'h00;
        rd = 8'h00;
        @(negedge clk);
        start = 1'b1; op = o; ret_addr = ra; target = tg; dir_addr = da; in_isr = isr;
        // cycle 1
        @(negedge clk);
        start = ghost; op = 3'd3; ret_addr = ~ra; target = ~tg; dir_addr = ~da; in_isr = ~isr;
        exp_busy = 1'b1;
        cmp_cycle(tag);
        check(!done, {tag, " R9 no early done"}, 32'(done), 32'd0);
        case (o)
            3'd0: check(ram_we && ram_addr == sp0 + 8'd1 && ram_wdata == ra[7:0],
                        {tag, " R4 low byte write"}, {ram_we, 15'd0, ram_addr, ram_wdata},
                        {1'b1, 15'd0, sp0 + 8'd1, ra[7:0]});
            3'd1, 3'd2: begin
                check(!ram_we && ram_addr == sp0, {tag, " R5 high byte read"},
                      {23'd0, ram_we, ram_addr}, {24'd0, sp0});
                hi = mem[sp0];
            end
            3'd3: begin
                check(!ram_we && ram_addr == da, {tag, " R2 source read"},
                      {23'd0, ram_we, ram_addr}, {24'd0, da});
                rd = mem[da];
            end
            default: begin
                check(!ram_we && ram_addr == sp0, {tag, " R3 stack read"},
                      {23'd0, ram_we, ram_addr}, {24'd0, sp0});
                rd = mem[sp0];
            end
        endcase
        if (o == 3'd0) exp_sp = exp_sp + 8'd1;
        else if (o != 3'd3) exp_sp = exp_sp - 8'd1;
        // cycle 2
        @(negedge clk);
        cmp_cycle(tag);
        check(done, {tag, " R9 done"}, 32'(done), 32'd1);
        check(irq_release == (o == 3'd2 && isr), {tag, " R6 release"},
              32'(irq_release), 32'(o == 3'd2 && isr));
        pc_e = exp_pc;
        case (o)
            3'd0: begin
                check(ram_we && ram_addr == sp0 + 8'd2 && ram_wdata == ra[15:8],
                      {tag, " R4 high byte write"}, {ram_we, 15'd0, ram_addr, ram_wdata},
                      {1'b1, 15'd0, sp0 + 8'd2, ra[15:8]});
                pc_e = tg;
            end
            3'd1, 3'd2: begin
                check(!ram_we && ram_addr == sp0 - 8'd1, {tag, " R5 low byte read"},
                      {23'd0, ram_we, ram_addr}, {24'd0, sp0 - 8'd1});
                pc_e = {hi, mem[sp0 - 8'd1]};
            end
            3'd3: check(ram_we && ram_addr == sp0 + 8'd1 && ram_wdata == rd,
                        {tag, " R2 stack write"}, {ram_we, 15'd0, ram_addr, ram_wdata},
                        {1'b1, 15'd0, sp0 + 8'd1, rd});
            default: check(ram_we && ram_addr == da && ram_wdata == rd,
                           {tag, " R3 dest write"}, {ram_we, 15'd0, ram_addr, ram_wdata},
                           {1'b1, 15'd0, da, rd});
        endcase
        check(pc_out == pc_e, {tag, " R4 R5 pc at done"}, 32'(pc_out), 32'(pc_e));
        exp_pc = pc_e;
        if (o == 3'd0 || o == 3'd3) exp_sp = exp_sp + 8'd1;
        else if (o != 3'd4) exp_sp = exp_sp - 8'd1;
        start = 1'b0;
        // back to idle
        @(negedge clk);
        exp_busy = 1'b0;
        cmp_cycle(tag);
        check(pc_out == exp_pc, {tag, " R4 R5 pc held"}, 32'(pc_out), 32'(exp_pc));
    endtask

    task automatic bad_op(input logic [2:0] o);
        @(negedge clk);
        start = 1'b1; op = o;
        @(negedge clk);
        start = 1'b0;
        cmp_cycle("R8 reserved code");
        @(negedge clk);
        cmp_cycle("R8 reserved code later");
        check(pc_out == exp_pc, "R8 pc untouched", 32'(pc_out), 32'(exp_pc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        exp_sp = 8'h07;
        exp_pc = 16'h0000;
        exp_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sp_out == 8'h07, "R1 sp reset", 32'(sp_out), 32'h07);
        check(pc_out == 16'h0, "R1 pc reset", 32'(pc_out), 32'h0);
        check(!busy && !done && !ram_we && !irq_release, "R1 idle flags",
              {28'd0, busy, done, ram_we, irq_release}, 32'd0);

        do_op(3'd3, 16'h0, 16'h0, 8'h30, 1'b0, 1'b0, "push A");
        do_op(3'd3, 16'h0, 16'h0, 8'h31, 1'b0, 1'b0, "push B");
        do_op(3'd4, 16'h0, 16'h0, 8'h40, 1'b0, 1'b0, "pop");
        check(mem[8'h40] == (8'h31 ^ 8'h5A), "R3 popped value stored",
              32'(mem[8'h40]), 32'(8'h31 ^ 8'h5A));
        do_op(3'd0, 16'h1234, 16'hABCD, 8'h0, 1'b0, 1'b0, "call");
        do_op(3'd1, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, "return");
        check(exp_pc == 16'h1234, "R5 return restores saved address", 32'(exp_pc), 32'h1234);
        do_op(3'd0, 16'hBEEF, 16'h0100, 8'h0, 1'b0, 1'b0, "call2");
        do_op(3'd2, 16'h0, 16'h0, 8'h0, 1'b1, 1'b0, "R6 reti in isr");
        do_op(3'd0, 16'h0102, 16'h0200, 8'h0, 1'b0, 1'b0, "call3");
        do_op(3'd2, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R6 reti outside isr");
        check(exp_pc == 16'h0102, "R6 reti like return", 32'(exp_pc), 32'h0102);
        bad_op(3'd5);
        bad_op(3'd6);
        bad_op(3'd7);
        // R8 start strobes held high through busy cycles
        do_op(3'd0, 16'h4321, 16'h0300, 8'h0, 1'b0, 1'b1, "R8 ghost call");
        do_op(3'd1, 16'h0, 16'h0, 8'h0, 1'b0, 1'b1, "R8 ghost return");
        // R7 downward wrap through pops
        for (int k = 0; k < 300 && exp_sp != 8'h01; k++)
            do_op(3'd4, 16'h0, 16'h0, 8'h80, 1'b0, 1'b0, "R7 pop walk");
        do_op(3'd4, 16'h0, 16'h0, 8'h81, 1'b0, 1'b0, "R7 pop to zero");
        do_op(3'd4, 16'h0, 16'h0, 8'h82, 1'b0, 1'b0, "R7 pop wrap");
        check(sp_out == 8'hFF, "R7 wrap below zero", 32'(sp_out), 32'hFF);
        // R7 upward wrap across a call
        do_op(3'd0, 16'h5566, 16'h0400, 8'h0, 1'b0, 1'b0, "R7 call wrap");
        check(sp_out == 8'h01 && mem[8'h00] == 8'h66 && mem[8'h01] == 8'h55,
              "R7 call across top", {8'd0, sp_out, mem[8'h00], mem[8'h01]}, 32'h00016655);
        do_op(3'd1, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R7 return wrap");
        check(pc_out == 16'h5566 && sp_out == 8'hFF, "R7 return across top",
              {8'd0, pc_out, sp_out}, 32'h005566FF);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule